// File: doc/BRIEF.md
# Serial Register Access Port

This block lets an external host read and write the 8-bit registers of a peripheral over a synchronous serial link. The host pulls the active-low select low to open a frame and supplies a shift clock that idles high. Bits go out from the block on the falling edge of the shift clock and are taken in on the rising edge. Every byte travels least significant bit first. The first byte of a frame names a register. The bytes after it carry data, and a direction pin chooses whether the host sends that data or receives it.

All host pins are resampled in the system clock domain. The block finds the shift-clock edges itself, so it needs no second clock domain. Each register access goes out on an internal port that holds a request until an acknowledge returns. While an access is pending, a wait output tells the host to hold off the next byte. The register address steps up by one after every data byte, so one frame can walk a run of consecutive registers.

Top module: `sreg_port`

## Requirements
- R1: Input bits are captured only on a rising edge of the resampled shift clock. The serial output register changes only on a falling edge, or to 0 when the frame closes.
- R2: Address and data bytes are shifted least significant bit first in both directions. The first bit on the wire is bit 0.
- R3: In a frame with the direction pin low (write), the first byte is taken as the register address. Each later byte is written to the register port at the current address with `reg_we` = 1.
- R4: In a frame with the direction pin high (read), the output bits during the address byte are 0. Each later byte returns the register value fetched from the port, starting at the given address.
- R5: `sdo_oe` is 1 exactly when the resampled select is low and the resampled direction pin is high. Both pins pass through a two-stage synchronizer.
- R6: The register address increases by one after every data byte in a frame and wraps from 0xFF to 0x00.
- R7: `xfer_wait` rises in the cycle after a byte that starts an access is complete. It stays high while `reg_req` is pending and drops in the cycle after `reg_ack`. With a one- or two-cycle acknowledge it is never high for more than 6 cycles.
- R8: If the select rises in the middle of a byte, the partial byte is discarded and no access is made. The next frame starts again with a fresh address byte.
- R9: The address byte of a write frame starts no register access, and `xfer_wait` stays low for it.
- R10: After reset, `sdo_oe`, `sdo`, `xfer_wait` and `reg_req` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 4x the shift clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Active-low frame select from the host |
| sclk | input | 1 | Host shift clock, idles high |
| sdi | input | 1 | Serial data from the host |
| rw_sel | input | 1 | Direction: 1 = host reads, 0 = host writes |
| sdo | output | 1 | Serial data to the host |
| sdo_oe | output | 1 | Output enable for `sdo`; the pad is high impedance when 0 |
| xfer_wait | output | 1 | High while an internal register access is pending |
| reg_req | output | 1 | Register access request, held until acknowledged |
| reg_we | output | 1 | 1 = write access, 0 = read access |
| reg_addr | output | 8 | Register address of the access |
| reg_wdata | output | 8 | Data for a write access |
| reg_rdata | input | 8 | Data returned for a read access, valid with `reg_ack` |
| reg_ack | input | 1 | One-cycle acknowledge that completes the access |

## Verification
The hardest case to reach from the ports is the select rising partway through a byte. The bench gets there by sending a full write address and then only four data bits before it raises the select. It then checks three things. The target register is unchanged. No wait pulse appeared. A read frame that follows, at the same address, lines up on byte boundaries, which it could only do if the bit counter had been cleared. A read frame starting at 0xFE crosses the address wrap, so the auto-increment is exercised where the counter rolls over.

// File: rtl/sreg_pkg.sv
package sreg_pkg;
  // Role of a completed byte within a frame
  typedef enum logic [1:0] {
    BK_NONE  = 2'd0,
    BK_ADDR  = 2'd1,
    BK_WDATA = 2'd2,
    BK_RDATA = 2'd3
  } byte_kind_e;
endpackage

// File: rtl/sreg_sync.sv
module sreg_sync #(
  parameter int N = 4,
  parameter int STAGES = 2,
  parameter logic [N-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] d,
  output logic [N-1:0] q
);
  generate
    for (genvar i = 0; i < N; i++) begin : g_bit
      logic [STAGES-1:0] chain;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain <= {STAGES{RST_VAL[i]}};
        else        chain <= {chain[STAGES-2:0], d[i]};
      end
      assign q[i] = chain[STAGES-1];
    end
  endgenerate
endmodule

// File: rtl/sreg_frame.sv
module sreg_frame #(
  parameter int DW = 8
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   cs_act,
  input  logic                   sclk_rise,
  input  logic                   sdi_s,
  input  logic                   rw_s,
  output logic                   byte_done,
  output logic [DW-1:0]          byte_val,
  output sreg_pkg::byte_kind_e   byte_kind,
  output logic                   in_data
);
  import sreg_pkg::*;
  localparam int CW = $clog2(DW);

  // New bit enters at the top; after DW shifts bit 0 holds the first bit sent
  function automatic logic [DW-1:0] shift_lsb_first(input logic [DW-1:0] cur, input logic b);
    return {b, cur[DW-1:1]};
  endfunction

  logic [CW-1:0] bitcnt;
  logic [DW-1:0] sh;
  logic          have_addr;
  logic          last_bit;

  assign last_bit = (bitcnt == CW'(DW-1));
  assign in_data  = have_addr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bitcnt    <= '0;
      sh        <= '0;
      have_addr <= 1'b0;
      byte_done <= 1'b0;
      byte_val  <= '0;
      byte_kind <= BK_NONE;
    end else begin
      byte_done <= 1'b0;
      if (!cs_act) begin
        bitcnt    <= '0;
        have_addr <= 1'b0;
      end else if (sclk_rise) begin
        sh <= shift_lsb_first(sh, sdi_s);
        if (last_bit) begin
          bitcnt    <= '0;
          byte_done <= 1'b1;
          byte_val  <= shift_lsb_first(sh, sdi_s);
          byte_kind <= !have_addr ? BK_ADDR : (rw_s ? BK_RDATA : BK_WDATA);
          have_addr <= 1'b1;
        end else begin
          bitcnt <= bitcnt + 1'b1;
        end
      end
    end
  end

  AST_DONE_FROM_RISE: assert property (@(posedge clk) disable iff (!rst_n)
    byte_done |-> $past(sclk_rise && cs_act)); // R1
  AST_ABORT_NO_BYTE: assert property (@(posedge clk) disable iff (!rst_n)
    !cs_act |=> !byte_done); // R8
endmodule

// File: rtl/sreg_access.sv
module sreg_access #(
  parameter int AW = 8,
  parameter int DW = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 byte_done,
  input  sreg_pkg::byte_kind_e byte_kind,
  input  logic [DW-1:0]        byte_val,
  input  logic                 rw_s,
  output logic                 reg_req,
  output logic                 reg_we,
  output logic [AW-1:0]        reg_addr,
  output logic [DW-1:0]        reg_wdata,
  input  logic [DW-1:0]        reg_rdata,
  input  logic                 reg_ack,
  output logic                 busy,
  output logic                 tx_load,
  output logic [DW-1:0]        tx_data
);
  import sreg_pkg::*;

  // Address step with natural wrap at the top of the space
  function automatic logic [AW-1:0] addr_step(input logic [AW-1:0] a);
    return a + 1'b1;
  endfunction

  logic [AW-1:0] cur_addr;
  logic [AW-1:0] rd_next;

  assign rd_next = addr_step(cur_addr);
  assign busy    = reg_req;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cur_addr  <= '0;
      reg_req   <= 1'b0;
      reg_we    <= 1'b0;
      reg_addr  <= '0;
      reg_wdata <= '0;
      tx_load   <= 1'b0;
      tx_data   <= '0;
    end else begin
      tx_load <= 1'b0;
      if (reg_req) begin
        if (reg_ack) begin
          reg_req <= 1'b0;
          if (reg_we) cur_addr <= addr_step(cur_addr);
          else begin
            tx_load <= 1'b1;
            tx_data <= reg_rdata;
          end
        end
      end else if (byte_done) begin
        unique case (byte_kind)
          BK_ADDR: begin
            cur_addr <= AW'(byte_val);
            if (rw_s) begin
              reg_req  <= 1'b1;
              reg_we   <= 1'b0;
              reg_addr <= AW'(byte_val);
            end
          end
          BK_WDATA: begin
            reg_req   <= 1'b1;
            reg_we    <= 1'b1;
            reg_addr  <= cur_addr;
            reg_wdata <= byte_val;
          end
          BK_RDATA: begin
            cur_addr <= rd_next;
            reg_req  <= 1'b1;
            reg_we   <= 1'b0;
            reg_addr <= rd_next;
          end
          default: ;
        endcase
      end
    end
  end

  AST_HOLD_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    reg_req && !reg_ack |=> reg_req && $stable(reg_addr) && $stable(reg_we)); // R7
  AST_WAIT_FALL: assert property (@(posedge clk) disable iff (!rst_n)
    reg_req && reg_ack |=> !busy); // R7
  AST_WAIT_RISE: assert property (@(posedge clk) disable iff (!rst_n)
    byte_done && !reg_req && (byte_kind == BK_WDATA || byte_kind == BK_RDATA) |=> busy); // R7
  AST_WR_ADDR_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    byte_done && !reg_req && byte_kind == BK_ADDR && !rw_s |=> !reg_req); // R9
  AST_LOAD_AFTER_READ: assert property (@(posedge clk) disable iff (!rst_n)
    tx_load |-> $past(reg_req && reg_ack && !reg_we)); // R4
endmodule

// File: rtl/sreg_port.sv
module sreg_port #(
  parameter int AW = 8,
  parameter int DW = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cs_n,
  input  logic          sclk,
  input  logic          sdi,
  input  logic          rw_sel,
  output logic          sdo,
  output logic          sdo_oe,
  output logic          xfer_wait,
  output logic          reg_req,
  output logic          reg_we,
  output logic [AW-1:0] reg_addr,
  output logic [DW-1:0] reg_wdata,
  input  logic [DW-1:0] reg_rdata,
  input  logic          reg_ack
);
  import sreg_pkg::*;

  logic [3:0]  pins_s;
  logic        cs_n_s, sclk_s, sdi_s, rw_s;
  logic        sclk_prev;
  logic        cs_act, sclk_rise, sclk_fall;
  logic        byte_done, in_data, tx_load;
  logic [DW-1:0] byte_val, tx_data, tx_sh;
  byte_kind_e  byte_kind;
  logic        sdo_q;

  // Bit order {rw, sdi, sclk, cs_n}; idle levels: select high, clock high
  sreg_sync #(.N(4), .STAGES(SYNC_STAGES), .RST_VAL(4'b0011)) u_sync (
    .clk(clk), .rst_n(rst_n), .d({rw_sel, sdi, sclk, cs_n}), .q(pins_s));

  assign {rw_s, sdi_s, sclk_s, cs_n_s} = pins_s;
  assign cs_act    = !cs_n_s;
  assign sclk_rise = sclk_s && !sclk_prev;
  assign sclk_fall = !sclk_s && sclk_prev;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sclk_prev <= 1'b1;
    else        sclk_prev <= sclk_s;
  end

  sreg_frame #(.DW(DW)) u_frame (
    .clk(clk), .rst_n(rst_n), .cs_act(cs_act), .sclk_rise(sclk_rise),
    .sdi_s(sdi_s), .rw_s(rw_s), .byte_done(byte_done), .byte_val(byte_val),
    .byte_kind(byte_kind), .in_data(in_data));

  sreg_access #(.AW(AW), .DW(DW)) u_access (
    .clk(clk), .rst_n(rst_n), .byte_done(byte_done), .byte_kind(byte_kind),
    .byte_val(byte_val), .rw_s(rw_s), .reg_req(reg_req), .reg_we(reg_we),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .reg_ack(reg_ack), .busy(xfer_wait), .tx_load(tx_load), .tx_data(tx_data));

  // Transmit side: fetched byte goes out bit 0 first, one bit per falling edge
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_sh <= '0;
      sdo_q <= 1'b0;
    end else if (!cs_act) begin
      sdo_q <= 1'b0;
    end else if (tx_load) begin
      tx_sh <= tx_data;
    end else if (sclk_fall && in_data && rw_s) begin
      sdo_q <= tx_sh[0];
      tx_sh <= tx_sh >> 1;
    end
  end

  assign sdo    = sdo_q;
  assign sdo_oe = cs_act && rw_s;

  AST_SDO_ON_FALL: assert property (@(posedge clk) disable iff (!rst_n)
    cs_act && !sclk_fall |=> $stable(sdo_q)); // R1
  AST_DUMMY_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
    !in_data |-> !sdo_q); // R4
endmodule

// File: tb/sim_sreg_port.sv
module sim_sreg_port;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cs_n = 1'b1, sclk = 1'b1, sdi = 1'b0, rw_sel = 1'b0;
  logic sdo, sdo_oe, xfer_wait, reg_req, reg_we, reg_ack = 1'b0;
  logic [7:0] reg_addr, reg_wdata, reg_rdata = 8'h00;

  int vectors = 0, fails = 0;
  logic [7:0] mem [256];
  logic [7:0] expmem [256];
  int ack_lat = 1, ack_cnt = 0;
  int wait_rises = 0, wait_len = 0;
  logic wait_d = 1'b0;
  logic h1 = 1'b0, h2 = 1'b0;
  bit run_cmp = 1'b0;

  always #2.5 clk = ~clk;  // 200 MHz

  sreg_port u0 (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sclk(sclk), .sdi(sdi), .rw_sel(rw_sel),
    .sdo(sdo), .sdo_oe(sdo_oe), .xfer_wait(xfer_wait), .reg_req(reg_req),
    .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .reg_ack(reg_ack));

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    vectors++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
    end
  endtask

  // Register file behind the port, with a selectable acknowledge latency
  always @(posedge clk) begin
    reg_ack <= 1'b0;
    if (reg_req && !reg_ack) begin
      if (ack_cnt + 1 >= ack_lat) begin
        reg_ack <= 1'b1;
        reg_rdata <= mem[reg_addr];
        if (reg_we) mem[reg_addr] = reg_wdata;
        ack_cnt = 0;
      end else ack_cnt++;
    end
  end

  // Per-clock reference: output enable follows select/direction two samples late
  always @(posedge clk) begin
    h2 <= h1;
    h1 <= !cs_n && rw_sel;
    if (xfer_wait && !wait_d) wait_rises++;
    wait_d <= xfer_wait;
  end

  always @(negedge clk) begin
    if (run_cmp) begin
      chk(sdo_oe == h2, "R5 oe", sdo_oe, h2);
      wait_len = xfer_wait ? wait_len + 1 : 0;
      if (wait_len > 6) chk(1'b0, "R7 wait length", wait_len, 6);
    end
  end

  task automatic xfer_byte(input logic [7:0] tx, output logic [7:0] rx);
    for (int i = 0; i < 8; i++) begin
      sclk = 1'b0;
      sdi = tx[i];
      repeat (4) @(negedge clk);
      rx[i] = sdo;
      sclk = 1'b1;
      repeat (4) @(negedge clk);
    end
    repeat (10) @(negedge clk);
  endtask

  task automatic run_frame(input bit rd, input logic [7:0] a, input int n, input logic [7:0] seed);
    logic [7:0] rx, d, ad;
    int r0;
    @(negedge clk);
    rw_sel = rd;
    cs_n = 1'b0;
    repeat (4) @(negedge clk);
    r0 = wait_rises;
    xfer_byte(a, rx);
    if (rd) begin
      chk(rx == 8'h00, "R4 dummy address-byte output", rx, 0);
      chk(wait_rises == r0 + 1, "R7 wait after read address", wait_rises, r0 + 1);
    end else
      chk(wait_rises == r0, "R9 no wait for write address", wait_rises, r0);
    for (int k = 0; k < n; k++) begin
      ad = a + 8'(k);
      if (rd) begin
        xfer_byte(8'h00, rx);
        chk(rx == expmem[ad], "R2/R4/R6 read byte", rx, expmem[ad]);
      end else begin
        d = seed + 8'(k * 37);
        xfer_byte(d, rx);
        expmem[ad] = d;
        chk(mem[ad] == d, "R2/R3/R6 written byte", mem[ad], d);
      end
    end
    repeat (4) @(negedge clk);
    cs_n = 1'b1;
    repeat (8) @(negedge clk);
  endtask

  initial begin
    logic [7:0] rx;
    int r0;
    for (int i = 0; i < 256; i++) begin
      mem[i] = 8'(i * 7 + 3);
      expmem[i] = 8'(i * 7 + 3);
    end
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(sdo_oe == 1'b0, "R10 reset oe", sdo_oe, 0);
    chk(sdo == 1'b0, "R10 reset sdo", sdo, 0);
    chk(xfer_wait == 1'b0, "R10 reset wait", xfer_wait, 0);
    chk(reg_req == 1'b0, "R10 reset req", reg_req, 0);
    run_cmp = 1'b1;

    // R3 R6: write three bytes, address auto-increments
    run_frame(1'b0, 8'h10, 3, 8'hA5);
    // R4 R2: read them back with asymmetric bit patterns
    run_frame(1'b1, 8'h10, 3, 8'h00);
    // R6: read across the address wrap
    run_frame(1'b1, 8'hFE, 3, 8'h00);
    ack_lat = 2;
    // R6: write across the wrap with a slower acknowledge
    run_frame(1'b0, 8'hFF, 2, 8'h3C);
    run_frame(1'b1, 8'hFF, 2, 8'h00);
    ack_lat = 1;
    // R9: address-only write frame
    run_frame(1'b0, 8'h20, 0, 8'h00);
    chk(mem[8'h20] == expmem[8'h20], "R9 register untouched", mem[8'h20], expmem[8'h20]);

    // R8: select rises after four data bits
    @(negedge clk);
    rw_sel = 1'b0;
    cs_n = 1'b0;
    repeat (4) @(negedge clk);
    xfer_byte(8'h40, rx);
    r0 = wait_rises;
    for (int i = 0; i < 4; i++) begin
      sclk = 1'b0;
      sdi = 1'b1;
      repeat (4) @(negedge clk);
      sclk = 1'b1;
      repeat (4) @(negedge clk);
    end
    cs_n = 1'b1;
    repeat (12) @(negedge clk);
    chk(wait_rises == r0, "R8 no access on abort", wait_rises, r0);
    chk(mem[8'h40] == expmem[8'h40], "R8 register kept", mem[8'h40], expmem[8'h40]);
    run_frame(1'b1, 8'h40, 2, 8'h00);
    // R1 R2: a single-bit pattern write and read
    run_frame(1'b0, 8'h81, 1, 8'h01);
    run_frame(1'b1, 8'h81, 1, 8'h00);

    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule